// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic on a single system clock (roughly 24 to 48 MHz) use an asynchronous 16-bit static RAM. The host side issues one request at a time. A request carries an address, write data, a two-bit byte mask and a read/write flag, and it is taken on any clock edge where `req_valid` and `req_ready` are both high. Read results come back as a registered word with a one-cycle valid pulse. The memory side drives address, a shared bidirectional data bus, and active-low chip select, output enable, write enable and per-lane byte selects. Every memory pin comes straight from a flip-flop on the system clock.

A write spans three clocks: setup, strobe and recovery. The write pulse is therefore one clock wide and sits inside a window where address and data stay unchanged. This meets zero-nanosecond setup and hold on both edges of the pulse. The parameter `STROBE_ON_LANES` picks the pulse. With the default value 0, WE pulses and the lane selects stay low for the whole write. With value 1, WE stays low for the whole write and the lane selects pulse instead. Reads are pipelined. An address is presented on one edge and the word is captured on the next edge, and the following address goes out on that same edge, so a run of reads completes one per clock.

The state machine has six states:
- ST_IDLE
- ST_WR_SETUP
- ST_WR_STROBE
- ST_WR_RECOVER
- ST_RD_ACCESS
- ST_TURN

Its transitions are:
- ST_IDLE goes to ST_WR_SETUP on a write request, to ST_RD_ACCESS on a read request, and otherwise stays.
- ST_WR_SETUP always goes to ST_WR_STROBE.
- ST_WR_STROBE always goes to ST_WR_RECOVER.
- ST_WR_RECOVER goes to ST_WR_SETUP on a write request, to ST_TURN on a read request, and otherwise to ST_IDLE.
- ST_RD_ACCESS stays on a read request, goes to ST_TURN on a write request, and otherwise goes to ST_IDLE.
- ST_TURN goes to ST_WR_SETUP or ST_RD_ACCESS, according to the request it holds.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, req_ready is 1, sram_cs_n, sram_oe_n and sram_we_n are 1, sram_lane_n is 2'b11 and rd_valid is 0.
- R2: With STROBE_ON_LANES=0, an accepted write occupies the three clocks after its acceptance edge (setup, strobe, recovery). sram_cs_n is 0 in all three. sram_we_n is 0 only in the middle clock. sram_lane_n follows the mask in all three.
- R3: During all three write clocks, sram_addr holds the request address and the data bus carries the request data, unchanged.
- R4: With STROBE_ON_LANES=1, sram_we_n is 0 in all three write clocks. sram_lane_n is 2'b11 in setup and recovery and follows the mask only in the strobe clock.
- R5: Mask bit 1 selects the upper lane (data bits 15:8, pin sram_lane_n[1]) and mask bit 0 selects the lower lane (bits 7:0, pin sram_lane_n[0]). A lane whose mask bit is 0 keeps its select high, so that byte of memory is left unchanged.
- R6: A write request presented during recovery is accepted on the edge that ends recovery. Its setup follows at once, sram_cs_n stays 0 across the run, and each write takes exactly three clocks.
- R7: A read accepted on an edge puts its address on sram_addr with sram_oe_n=0 and sram_cs_n=0 in the next clock. The word is registered at the end of that clock and shown on rd_data one clock later. A read request during ST_RD_ACCESS is accepted on the same edge, giving one read per clock.
- R8: The controller drives the data bus only in write clocks and keeps sram_oe_n high in them. sram_oe_n is 0 only in read clocks.
- R9: A read that follows a write recovery, or a write that follows a read, is preceded by exactly one clock with sram_cs_n=1 and sram_oe_n=1.
- R10: rd_valid is high for exactly one clock per read, and rd_data words appear in request order.
- R11: req_ready is 1 only in idle, write recovery and read access clocks. It is 0 in write setup, write strobe and turnaround clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes a request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| rd_valid | output | 1 | One-cycle read result flag |
| rd_data | output | DATA_W | Registered read word |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq | inout | DATA_W | Memory data bus |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_lane_n | output | DATA_W/8 | Byte lane selects, active low |

## Verification
For a write accepted at edge k, the setup, strobe and recovery pin values fall in clocks k+1, k+2 and k+3. For a read accepted at edge k, the address and OE are visible in clock k+1 and the valid word in clock k+2. A turnaround inserts one extra clock before the new direction starts. The bench drives inputs and samples pins at the falling edge. Each scenario task steps one falling edge at a time from the cycle in which its request was taken, and checks the pins expected in that exact clock. A rising-edge monitor counts strobe cycles, select-high cycles, direction changes without a gap, and tags each valid word with its cycle number. This lets run lengths and read order be compared against those offsets.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WR_SETUP   = 3'd1,
        ST_WR_STROBE  = 3'd2,
        ST_WR_RECOVER = 3'd3,
        ST_RD_ACCESS  = 3'd4,
        ST_TURN       = 3'd5
    } ctrl_state_t;

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int LANES           = 2,
    parameter bit STROBE_ON_LANES = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_be,
    input  logic [LANES-1:0] be_hold,
    input  logic             wr_hold,
    output logic             req_ready,
    output logic             accept,
    output logic             in_read,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] lane_n,
    output logic             drive_en
);

    ctrl_state_t     state;
    ctrl_state_t     nx;
    logic            wr_nx;
    logic [LANES-1:0] be_sel;

    assign req_ready = (state == ST_IDLE) || (state == ST_WR_RECOVER) ||
                       (state == ST_RD_ACCESS);
    assign accept    = req_valid && req_ready;
    assign in_read   = (state == ST_RD_ACCESS);
    assign be_sel    = accept ? req_be : be_hold;
    assign wr_nx     = (nx == ST_WR_SETUP) || (nx == ST_WR_STROBE) ||
                       (nx == ST_WR_RECOVER);

    // next-state decision
    always_comb begin
        nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) nx = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            end
            ST_WR_SETUP:   nx = ST_WR_STROBE;
            ST_WR_STROBE:  nx = ST_WR_RECOVER;
            ST_WR_RECOVER: begin
                if (req_valid) nx = req_write ? ST_WR_SETUP : ST_TURN;
                else           nx = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (req_valid) nx = req_write ? ST_TURN : ST_RD_ACCESS;
                else           nx = ST_IDLE;
            end
            ST_TURN:       nx = wr_hold ? ST_WR_SETUP : ST_RD_ACCESS;
            default:       nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nx;
    end

    // registered pin outputs shared by both strobe variants
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n     <= 1'b1;
            oe_n     <= 1'b1;
            drive_en <= 1'b0;
        end else begin
            cs_n     <= (nx == ST_IDLE) || (nx == ST_TURN);
            oe_n     <= (nx != ST_RD_ACCESS);
            drive_en <= wr_nx;
        end
    end

    generate
        if (STROBE_ON_LANES) begin : g_lane_strobe
            always_ff @(posedge clk) begin
                if (rst) begin
                    we_n   <= 1'b1;
                    lane_n <= '1;
                end else begin
                    we_n <= !wr_nx;
                    if (nx == ST_WR_STROBE)      lane_n <= ~be_sel;
                    else if (nx == ST_RD_ACCESS) lane_n <= '0;
                    else                         lane_n <= '1;
                end
            end

            // R4: lanes only pulse while WE is held low for the write
            assert_lane_under_we_R4: assert property (@(posedge clk) disable iff (rst)
                ((lane_n != '1) && oe_n) |-> !we_n);
            // R4: the lane pulse lasts a single clock
            assert_lane_pulse_R4: assert property (@(posedge clk) disable iff (rst)
                ((lane_n != '1) && oe_n) |=> (lane_n == '1));
        end else begin : g_we_strobe
            always_ff @(posedge clk) begin
                if (rst) begin
                    we_n   <= 1'b1;
                    lane_n <= '1;
                end else begin
                    we_n <= (nx != ST_WR_STROBE);
                    if (wr_nx)                   lane_n <= ~be_sel;
                    else if (nx == ST_RD_ACCESS) lane_n <= '0;
                    else                         lane_n <= '1;
                end
            end

            // R2: WE pulse is one clock wide
            assert_we_pulse_R2: assert property (@(posedge clk) disable iff (rst)
                !we_n |=> we_n);
            // R2: the pulse is preceded by a selected setup clock
            assert_we_setup_R2: assert property (@(posedge clk) disable iff (rst)
                $fell(we_n) |-> (!cs_n && $past(!cs_n) && $past(we_n)));
        end
    endgenerate

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              in_read,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_hold,
    output logic              wr_hold,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // request holding registers, loaded once per accepted request
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_hold <= '0;
            wr_hold <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_hold <= req_be;
            wr_hold <= req_write;
        end
    end

    // read capture: the edge that ends an access clock takes the bus word
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= in_read;
            if (in_read) rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
    parameter int ADDR_W          = 18,
    parameter int DATA_W          = 16,
    parameter bit STROBE_ON_LANES = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     sram_addr,
    inout  wire  [DATA_W-1:0]     sram_dq,
    output logic                  sram_cs_n,
    output logic                  sram_oe_n,
    output logic                  sram_we_n,
    output logic [DATA_W/8-1:0]   sram_lane_n
);

    localparam int LANES = DATA_W / 8;

    logic             accept;
    logic             in_read;
    logic             drive_en;
    logic [LANES-1:0] be_hold;
    logic             wr_hold;
    logic [DATA_W-1:0] wdata_q;
    logic             strobe_on;

    sram_ctrl_fsm #(
        .LANES          (LANES),
        .STROBE_ON_LANES(STROBE_ON_LANES)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_be   (req_be),
        .be_hold  (be_hold),
        .wr_hold  (wr_hold),
        .req_ready(req_ready),
        .accept   (accept),
        .in_read  (in_read),
        .cs_n     (sram_cs_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .lane_n   (sram_lane_n),
        .drive_en (drive_en)
    );

    sram_ctrl_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LANES (LANES)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_be   (req_be),
        .in_read  (in_read),
        .dq_in    (sram_dq),
        .addr_q   (sram_addr),
        .wdata_q  (wdata_q),
        .be_hold  (be_hold),
        .wr_hold  (wr_hold),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign sram_dq = drive_en ? wdata_q : {DATA_W{1'bz}};

    generate
        if (STROBE_ON_LANES) begin : g_strobe_lanes
            assign strobe_on = (sram_lane_n != '1) && sram_oe_n && !sram_cs_n;
        end else begin : g_strobe_we
            assign strobe_on = !sram_we_n;
        end
    endgenerate

    // R3: address and data unchanged from setup into strobe
    assert_hold_into_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        strobe_on |-> ($stable(sram_addr) && $stable(wdata_q)));
    // R3: address and data unchanged from strobe into recovery
    assert_hold_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        strobe_on |=> ($stable(sram_addr) && $stable(wdata_q)));
    // R8: controller never drives while the memory output is enabled
    assert_bus_owner_R8: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> sram_oe_n);
    // R9: read enable never directly follows a driven clock
    assert_turn_into_read_R9: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> !$past(drive_en));
    // R9: driving never directly follows a read-enabled clock
    assert_turn_into_write_R9: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> $past(sram_oe_n));
    // R11: no request is taken during the strobe clock
    assert_no_ready_in_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        strobe_on |-> !req_ready);
    // R11: recovery clock is ready for the next request
    assert_ready_in_recovery_R11: assert property (@(posedge clk) disable iff (rst)
        $past(strobe_on) |-> req_ready);

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;

    logic        ready_a, rdv_a, cs_a, oe_a, we_a;
    logic [15:0] rdd_a;
    logic [17:0] addr_a;
    logic [1:0]  lane_a;
    wire  [15:0] dq_a;

    logic        ready_b, rdv_b, cs_b, oe_b, we_b;
    logic [15:0] rdd_b;
    logic [17:0] addr_b;
    logic [1:0]  lane_b;
    wire  [15:0] dq_b;

    logic [15:0] mem_a [256];
    logic [15:0] mem_b [256];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int cyc = 0;
    int we_low_a = 0;
    int lane_strobe_b = 0;
    int cs_high_a = 0;
    int turn_viol = 0;
    int rd_cnt_a = 0;
    int rd_cnt_b = 0;
    logic [15:0] rd_log_a [64];
    logic [15:0] rd_log_b [64];
    int          rd_cyc_a [64];
    bit prev_wr = 1'b0;
    bit prev_rd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctrl #(.ADDR_W(18), .DATA_W(16), .STROBE_ON_LANES(1'b0)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready_a),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rdv_a), .rd_data(rdd_a),
        .sram_addr(addr_a), .sram_dq(dq_a), .sram_cs_n(cs_a),
        .sram_oe_n(oe_a), .sram_we_n(we_a), .sram_lane_n(lane_a));

    sram_ctrl #(.ADDR_W(18), .DATA_W(16), .STROBE_ON_LANES(1'b1)) uut_lane (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready_b),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rdv_b), .rd_data(rdd_b),
        .sram_addr(addr_b), .sram_dq(dq_b), .sram_cs_n(cs_b),
        .sram_oe_n(oe_b), .sram_we_n(we_b), .sram_lane_n(lane_b));

    // memory models: drive the bus when selected and output-enabled
    assign dq_a = (!cs_a && !oe_a && we_a) ? mem_a[addr_a[7:0]] : 16'hzzzz;
    assign dq_b = (!cs_b && !oe_b && we_b) ? mem_b[addr_b[7:0]] : 16'hzzzz;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_a[i] = 16'h0000;
            mem_b[i] = 16'h0000;
        end
    end

    // memory write model and monitor, sampling the clock that just ended
    always @(posedge clk) begin
        if (!rst) begin
            for (int l = 0; l < 2; l++) begin
                if (!cs_a && !we_a && !lane_a[l]) mem_a[addr_a[7:0]][l*8 +: 8] <= dq_a[l*8 +: 8];
                if (!cs_b && !we_b && !lane_b[l]) mem_b[addr_b[7:0]][l*8 +: 8] <= dq_b[l*8 +: 8];
            end
            if (!cs_a && !we_a) we_low_a++;
            if (!cs_b && oe_b && (lane_b != 2'b11)) lane_strobe_b++;
            if (cs_a) cs_high_a++;
            if ((!cs_a && !oe_a && prev_wr) || (!cs_a && oe_a && prev_rd)) turn_viol++;
            prev_wr = !cs_a && oe_a;
            prev_rd = !cs_a && !oe_a;
            if (rdv_a) begin
                rd_log_a[rd_cnt_a % 64] = rdd_a;
                rd_cyc_a[rd_cnt_a % 64] = cyc;
                rd_cnt_a++;
            end
            if (rdv_b) begin
                rd_log_b[rd_cnt_b % 64] = rdd_b;
                rd_cnt_b++;
            end
        end
        cyc++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present a request and return at the falling edge after its acceptance
    task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        while (!ready_a) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_expect(input logic [17:0] a, input logic [15:0] exp,
                               input string req);
        issue(1'b0, a, 16'h0, 2'b00);
        chk(!oe_a && !cs_a && addr_a == a, {req, " read address phase"}, {oe_a, addr_a}, {1'b0, a});
        @(negedge clk);
        chk(rdv_a && rdd_a == exp, {req, " read data uut"}, rdd_a, exp);
        chk(rdv_b && rdd_b == exp, {req, " read data uut_lane"}, rdd_b, exp);
        @(negedge clk);
        chk(!rdv_a, "R10 valid single cycle", rdv_a, 0);
    endtask

    task automatic t_reset();
        chk(ready_a && ready_b, "R1 ready after reset", {ready_a, ready_b}, 2'b11);
        chk(cs_a && oe_a && we_a && cs_b && oe_b && we_b, "R1 strobes high",
            {cs_a, oe_a, we_a, cs_b, oe_b, we_b}, 6'h3f);
        chk(lane_a == 2'b11 && lane_b == 2'b11, "R1 lanes high", {lane_a, lane_b}, 4'hf);
        chk(!rdv_a && !rdv_b, "R1 no read valid", {rdv_a, rdv_b}, 0);
    endtask

    task automatic t_single_write();
        issue(1'b1, 18'h00005, 16'hA5A5, 2'b11);
        // setup clock
        chk(!cs_a && oe_a && we_a, "R2 setup pins", {cs_a, oe_a, we_a}, 3'b011);
        chk(lane_a == 2'b00, "R2 lanes in setup", lane_a, 2'b00);
        chk(addr_a == 18'h5 && dq_a == 16'hA5A5, "R3 setup addr/data", {addr_a, dq_a}, {18'h5, 16'hA5A5});
        chk(!we_b && lane_b == 2'b11, "R4 lane mode setup", {we_b, lane_b}, 3'b011);
        chk(!ready_a, "R11 not ready in setup", ready_a, 0);
        @(negedge clk);
        // strobe clock
        chk(!we_a && lane_a == 2'b00, "R2 strobe clock", {we_a, lane_a}, 3'b000);
        chk(!we_b && lane_b == 2'b00, "R4 lane strobe clock", {we_b, lane_b}, 3'b000);
        chk(addr_a == 18'h5 && dq_a == 16'hA5A5, "R3 strobe addr/data", {addr_a, dq_a}, {18'h5, 16'hA5A5});
        chk(!ready_a, "R11 not ready in strobe", ready_a, 0);
        @(negedge clk);
        // recovery clock
        chk(we_a && !cs_a, "R2 recovery pins", {we_a, cs_a}, 2'b10);
        chk(!we_b && lane_b == 2'b11, "R4 lane recovery", {we_b, lane_b}, 3'b011);
        chk(addr_a == 18'h5 && dq_a == 16'hA5A5, "R3 recovery addr/data", {addr_a, dq_a}, {18'h5, 16'hA5A5});
        chk(ready_a, "R11 ready in recovery", ready_a, 1);
        @(negedge clk);
        chk(cs_a && we_a && we_b, "R2 idle after write", {cs_a, we_a, we_b}, 3'b111);
        chk(mem_a[5] == 16'hA5A5 && mem_b[5] == 16'hA5A5, "R2 word stored",
            mem_a[5], 16'hA5A5);
    endtask

    task automatic t_mask();
        issue(1'b1, 18'h00040, 16'h1234, 2'b11);
        idle(3);
        issue(1'b1, 18'h00040, 16'hABCD, 2'b01);
        chk(lane_a == 2'b10, "R5 upper lane held high", lane_a, 2'b10);
        chk(lane_b == 2'b11, "R5 lane mode setup", lane_b, 2'b11);
        @(negedge clk);
        chk(lane_b == 2'b10, "R5 lane mode strobe lower only", lane_b, 2'b10);
        idle(3);
        read_expect(18'h00040, 16'h12CD, "R5");
    endtask

    task automatic t_back2back();
        int c0, cs0, we0, ln0;
        issue(1'b1, 18'h00020, 16'h1111, 2'b11);
        c0 = cyc; cs0 = cs_high_a; we0 = we_low_a; ln0 = lane_strobe_b;
        issue(1'b1, 18'h00021, 16'h2222, 2'b11);
        chk(cyc - c0 == 3, "R6 second write three clocks later", cyc - c0, 3);
        issue(1'b1, 18'h00022, 16'h3333, 2'b11);
        idle(2);
        chk(cyc - c0 == 8, "R6 run length", cyc - c0, 8);
        chk(cs_high_a == cs0, "R6 select held across run", cs_high_a - cs0, 0);
        chk(we_low_a - we0 == 3, "R6 one WE pulse per write", we_low_a - we0, 3);
        chk(lane_strobe_b - ln0 == 3, "R4 one lane pulse per write", lane_strobe_b - ln0, 3);
        idle(2);
    endtask

    task automatic t_pipe_read();
        int c0, n0, nb;
        logic [15:0] exp [4];
        exp[0] = 16'h1111; exp[1] = 16'h2222; exp[2] = 16'h3333; exp[3] = 16'h12CD;
        n0 = rd_cnt_a; nb = rd_cnt_b;
        issue(1'b0, 18'h00020, 16'h0, 2'b00);
        c0 = cyc;
        chk(!oe_a && !cs_a && addr_a == 18'h20, "R7 first address with OE", {oe_a, addr_a}, {1'b0, 18'h20});
        issue(1'b0, 18'h00021, 16'h0, 2'b00);
        chk(cyc - c0 == 1 && addr_a == 18'h21, "R7 next address one clock later", addr_a, 18'h21);
        issue(1'b0, 18'h00022, 16'h0, 2'b00);
        issue(1'b0, 18'h00040, 16'h0, 2'b00);
        idle(4);
        chk(rd_cnt_a - n0 == 4, "R10 one valid per read", rd_cnt_a - n0, 4);
        for (int i = 0; i < 4; i++) begin
            chk(rd_log_a[(n0 + i) % 64] == exp[i], "R10 read order", rd_log_a[(n0 + i) % 64], exp[i]);
            chk(rd_cyc_a[(n0 + i) % 64] == c0 + 1 + i, "R7 read latency", rd_cyc_a[(n0 + i) % 64], c0 + 1 + i);
            chk(rd_log_b[(nb + i) % 64] == exp[i], "R7 lane mode read", rd_log_b[(nb + i) % 64], exp[i]);
        end
    endtask

    task automatic t_turn();
        int v0;
        v0 = turn_viol;
        // write then read
        issue(1'b1, 18'h00055, 16'h5A5A, 2'b11);
        issue(1'b0, 18'h00055, 16'h0, 2'b00);
        chk(cs_a && oe_a, "R9 gap before read", {cs_a, oe_a}, 2'b11);
        chk(!ready_a, "R11 not ready in turnaround", ready_a, 0);
        @(negedge clk);
        chk(!cs_a && !oe_a && addr_a == 18'h55, "R8 read after gap", {cs_a, oe_a}, 2'b00);
        @(negedge clk);
        chk(rdv_a && rdd_a == 16'h5A5A, "R9 read after write data", rdd_a, 16'h5A5A);
        idle(2);
        // read then write
        issue(1'b0, 18'h00055, 16'h0, 2'b00);
        issue(1'b1, 18'h00056, 16'h6666, 2'b11);
        chk(cs_a && oe_a, "R9 gap before write", {cs_a, oe_a}, 2'b11);
        chk(rdv_a && rdd_a == 16'h5A5A, "R7 read completes in gap", rdd_a, 16'h5A5A);
        @(negedge clk);
        chk(!cs_a && oe_a && we_a, "R8 write setup after gap", {cs_a, oe_a, we_a}, 3'b011);
        chk(!rdv_a, "R10 valid single cycle", rdv_a, 0);
        idle(4);
        chk(mem_a[8'h56] == 16'h6666, "R9 write after read stored", mem_a[8'h56], 16'h6666);
        chk(turn_viol == v0, "R9 no direction change without gap", turn_viol - v0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        @(negedge clk);
        t_single_write();
        t_mask();
        t_back2back();
        t_pipe_read();
        t_turn();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule